// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Acceptance Unit

This unit sits beside a CPU core and decides, every cycle, whether a pending interrupt is taken. Each maskable source raises a one-cycle set pulse that latches a pending bit. Each source carries a 3-bit priority level, where level 0 means the source is switched off. A separate non-maskable input latches its own pending flag. The unit holds the processor status: an enable flag, a stack-select flag and a 3-bit current priority level. The core can overwrite that status through a write port, for example when it returns from a handler. It also reports executed software interrupts, so that low-numbered ones can switch the stack selection.

When a request is taken, the unit pulses an accept strobe for one cycle. It presents the winning vector number and the status as it stood just before acceptance, so the core can stack it. It then rewrites the status: enable cleared, interrupt stack selected, priority level raised. Fetching the vector, stacking registers and sequencing instructions belong to the core.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, accept_o is 0 and status_o, saved_o, vector_o and pend_o are all zero.
- R2: A 1 on req_set_i[i] at a clock edge sets pend_o[i] from that edge on. The bit stays set until that source is accepted. A set pulse in the same cycle as the clear wins, and the bit stays 1.
- R3: A maskable source is taken only when the enable flag (status bit 0) is 1 and its level is strictly greater than the current priority level (status bits 4:2). An equal level is not enough.
- R4: A source programmed to level 0 is never taken. Its pending bit stays set.
- R5: Among pending, eligible sources, the highest level wins. When levels tie, the lowest index wins. vector_o shows the winner's index.
- R6: On a maskable acceptance, status_o becomes enable 0, stack-select (bit 1) 0 and priority level equal to the winner's level. saved_o holds the status from before the acceptance.
- R7: accept_o is a one-cycle pulse. It is high on the edge after the decision cycle, which is two edges after the set pulse at the earliest. The winner's pending bit clears on that same edge.
- R8: A pending non-maskable request is taken regardless of the enable flag and the priority level, and it has precedence over maskable sources. acc_nmi_o pulses with accept_o, vector_o reads 0, and status becomes priority level 7 with both flags 0.
- R9: st_wr_i loads st_wdata_i into the status on the next edge. If an acceptance is decided in that same cycle, the acceptance update wins.
- R10: swi_i with swi_num_i below 32 clears the stack-select flag on the next edge. A number of 32 or more leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_set_i | input | N_SRC | Per-source pending set pulses |
| req_lvl_i | input | 3*N_SRC | Per-source priority level, source i in bits 3i+2:3i |
| nmi_i | input | 1 | Non-maskable request pulse |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 5 | Status to write: [4:2] level, [1] stack-select, [0] enable |
| swi_i | input | 1 | A software interrupt was executed |
| swi_num_i | input | 6 | Number of that software interrupt |
| accept_o | output | 1 | Acceptance strobe |
| acc_nmi_o | output | 1 | Acceptance was the non-maskable request |
| vector_o | output | VEC_W | Index of the last accepted source |
| status_o | output | 5 | Current status, same layout as st_wdata_i |
| saved_o | output | 5 | Status captured at the last acceptance |
| pend_o | output | N_SRC | Pending bits |

## Verification
The checker watches a set of properties on every cycle:
- every maskable acceptance came from an enabled status, and the priority level rose strictly;
- every acceptance leaves both flags cleared;
- a non-maskable acceptance sets level 7;
- the winner's pending bit is gone, unless it was set again.

Some behaviour only the bench's scenarios can show:
- that the winner is the highest-level, lowest-index source;
- that equal-level and level-0 requests are held off;
- the precedence of acceptance over a status write in the same cycle;
- the software-interrupt number boundary at 32.

A cycle-accurate reference model, driven by randomly chosen inputs, covers the interleaving of set pulses, non-maskable pulses and status writes.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt acceptance unit.
// Assumes a fixed 3-bit priority field and a 6-bit software interrupt number.
package irq_pkg;
    localparam int LVL_W   = 3;
    localparam int SWI_W   = 6;
    localparam logic [LVL_W-1:0] NMI_LVL = 3'd7;

    typedef struct packed {
        logic [LVL_W-1:0] ipl;   // current processor priority level
        logic             stk;   // 1: user stack, 0: interrupt stack
        logic             ien;   // maskable interrupts allowed
    } irq_stat_t;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending-bit bank: one flop per source, set by pulse, cleared on acceptance.
// Assumes set and clear may coincide; the set wins so a fresh request is kept.
module irq_pend_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        // Hold, clear on acceptance, set on request.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_o[g] <= 1'b0;
            else        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational priority search over pending sources.
// Picks the highest non-zero level; ties go to the lowest index.
// Reports level 0 when no source is eligible.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 3
) (
    input  logic [N_SRC-1:0]       pend_i,
    input  logic [N_SRC*LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0]       best_lvl_o,
    output logic [VEC_W-1:0]       best_idx_o
);
    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        best_lvl_o = '0;
        best_idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] > best_lvl_o)) begin
                best_lvl_o = lvl_i[i*LVL_W +: LVL_W];
                best_idx_o = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
// Processor status register with the acceptance update and a saved copy.
// Update order within one cycle: core write, then software-interrupt stack
// clear, then acceptance (the last one wins).
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int SWI_LIMIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  irq_stat_t        wdata_i,
    input  logic             swi_i,
    input  logic [SWI_W-1:0] swi_num_i,
    input  logic             take_nmi_i,
    input  logic             take_msk_i,
    input  logic [LVL_W-1:0] acc_lvl_i,
    output irq_stat_t        stat_o,
    output irq_stat_t        saved_o
);
    irq_stat_t nxt;

    // Compose the next status from the prioritised update sources.
    always_comb begin
        nxt = stat_o;
        if (wr_i) nxt = wdata_i;
        if (swi_i && (swi_num_i < SWI_W'(SWI_LIMIT))) nxt.stk = 1'b0;
        if (take_nmi_i || take_msk_i) begin
            nxt.ien = 1'b0;
            nxt.stk = 1'b0;
            nxt.ipl = take_nmi_i ? NMI_LVL : acc_lvl_i;
        end
    end

    // Status register and the copy captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o  <= '0;
            saved_o <= '0;
        end else begin
            stat_o <= nxt;
            if (take_nmi_i || take_msk_i) saved_o <= stat_o;
        end
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
// Top of the interrupt acceptance unit. Latches requests, arbitrates on the
// registered pending bits, and issues a registered one-cycle accept strobe
// together with the updated status. Assumes the core samples the outputs
// in the cycle accept_o is high.
module irq_accept_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int SWI_LIMIT = 32,
    localparam int VEC_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req_set_i,
    input  logic [N_SRC*LVL_W-1:0] req_lvl_i,
    input  logic                   nmi_i,
    input  logic                   st_wr_i,
    input  logic [4:0]             st_wdata_i,
    input  logic                   swi_i,
    input  logic [SWI_W-1:0]       swi_num_i,
    output logic                   accept_o,
    output logic                   acc_nmi_o,
    output logic [VEC_W-1:0]       vector_o,
    output logic [4:0]             status_o,
    output logic [4:0]             saved_o,
    output logic [N_SRC-1:0]       pend_o
);
    logic             nmi_pend;
    logic [LVL_W-1:0] best_lvl;
    logic [VEC_W-1:0] best_idx;
    logic             take_nmi, take_msk;
    logic [N_SRC-1:0] clr;
    irq_stat_t        stat, saved;

    irq_pend_bank #(.N_SRC(N_SRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .set_i(req_set_i), .clr_i(clr), .pend_o(pend_o)
    );

    irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) arb_i (
        .pend_i(pend_o), .lvl_i(req_lvl_i),
        .best_lvl_o(best_lvl), .best_idx_o(best_idx)
    );

    // Acceptance decision: non-maskable first, then the gated maskable winner.
    always_comb begin
        take_nmi = nmi_pend;
        take_msk = !nmi_pend && stat.ien && (best_lvl > stat.ipl);
        clr      = take_msk ? (N_SRC'(1) << best_idx) : '0;
    end

    irq_status_unit #(.SWI_LIMIT(SWI_LIMIT)) stat_i (
        .clk(clk), .rst_n(rst_n),
        .wr_i(st_wr_i), .wdata_i(irq_stat_t'(st_wdata_i)),
        .swi_i(swi_i), .swi_num_i(swi_num_i),
        .take_nmi_i(take_nmi), .take_msk_i(take_msk), .acc_lvl_i(best_lvl),
        .stat_o(stat), .saved_o(saved)
    );

    // Non-maskable pending flag; a new pulse survives a same-cycle acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend <= 1'b0;
        else        nmi_pend <= (nmi_pend & ~take_nmi) | nmi_i;
    end

    // Registered strobe and vector toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o  <= 1'b0;
            acc_nmi_o <= 1'b0;
            vector_o  <= '0;
        end else begin
            accept_o  <= take_nmi | take_msk;
            acc_nmi_o <= take_nmi;
            if (take_nmi)      vector_o <= '0;
            else if (take_msk) vector_o <= best_idx;
        end
    end

    assign status_o = stat;
    assign saved_o  = saved;
endmodule

// File: rtl/irq_accept_chk.sv
// Cycle-by-cycle properties of the acceptance unit, bound to its top.
module irq_accept_chk #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] req_set_i,
    input logic             accept_o,
    input logic             acc_nmi_o,
    input logic [VEC_W-1:0] vector_o,
    input logic [4:0]       status_o,
    input logic [4:0]       saved_o,
    input logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] set_q;

    // Remember the previous cycle's set pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= '0;
        else        set_q <= req_set_i;
    end

    AST_MSK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !acc_nmi_o) |-> (saved_o[0] && (status_o[4:2] > saved_o[4:2]))); // R3
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (status_o[1:0] == 2'b00)); // R6
    AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nmi_o |-> (accept_o && status_o[4:2] == 3'd7 && vector_o == '0)); // R8
    AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !acc_nmi_o) |-> (!pend_o[vector_o] || set_q[vector_o])); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!accept_o && status_o == 5'd0)); // R1
endmodule

bind irq_accept_ctrl irq_accept_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .accept_o(accept_o),
    .acc_nmi_o(acc_nmi_o), .vector_o(vector_o), .status_o(status_o),
    .saved_o(saved_o), .pend_o(pend_o)
);

// File: tb/irq_accept_ctrl_tb_top.sv
module irq_accept_ctrl_tb_top;
    localparam int N = 8;
    localparam int VW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   req_set = '0;
    logic [N*3-1:0] req_lvl = '0;
    logic nmi = 1'b0, st_wr = 1'b0, swi = 1'b0;
    logic [4:0] st_wdata = '0;
    logic [5:0] swi_num = '0;
    logic accept, acc_nmi;
    logic [VW-1:0] vector;
    logic [4:0] status, saved;
    logic [N-1:0] pend;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    // Reference model state
    logic [N-1:0] m_pend = '0;
    logic m_nmi = 1'b0, m_acc = 1'b0, m_accn = 1'b0;
    logic [4:0] m_st = '0, m_saved = '0;
    logic [VW-1:0] m_vec = '0;

    always #10 clk = ~clk;

    irq_accept_ctrl #(.N_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .req_lvl_i(req_lvl),
        .nmi_i(nmi), .st_wr_i(st_wr), .st_wdata_i(st_wdata), .swi_i(swi),
        .swi_num_i(swi_num), .accept_o(accept), .acc_nmi_o(acc_nmi),
        .vector_o(vector), .status_o(status), .saved_o(saved), .pend_o(pend)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of one clock edge, built from the requirements.
    task automatic model_step();
        logic [2:0] best = 0;
        logic [VW-1:0] bidx = 0;
        logic tn, tm;
        logic [4:0] ns;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && req_lvl[i*3 +: 3] > best) begin
                best = req_lvl[i*3 +: 3]; bidx = VW'(i);
            end
        tn = m_nmi;
        tm = !tn && m_st[0] && (best > m_st[4:2]);
        ns = m_st;
        if (st_wr) ns = st_wdata;
        if (swi && swi_num < 6'd32) ns[1] = 1'b0;
        if (tn) ns = {3'd7, 2'b00};
        if (tm) ns = {best, 2'b00};
        if (tn || tm) m_saved = m_st;
        if (tn) m_vec = '0; else if (tm) m_vec = bidx;
        m_acc = tn || tm;
        m_accn = tn;
        if (tm) m_pend[bidx] = 1'b0;
        m_pend = m_pend | req_set;
        m_nmi = (m_nmi && !tn) || nmi;
        m_st = ns;
    endtask

    task automatic compare_model();
        chk("R7 accept vs model", accept, m_acc);
        chk("R8 nmi flag vs model", acc_nmi, m_accn);
        chk("R5 vector vs model", vector, m_vec);
        chk("R6 status vs model", status, m_st);
        chk("R6 saved vs model", saved, m_saved);
        chk("R2 pending vs model", pend, m_pend);
    endtask

    // Apply current inputs across one edge, then check at the falling edge.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        req_set = '0; nmi = 1'b0; st_wr = 1'b0; swi = 1'b0;
    endtask

    task automatic set_lvl(int idx, int l);
        req_lvl[idx*3 +: 3] = 3'(l);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset accept", accept, 0);
        chk("R1 reset status", status, 0);
        chk("R1 reset pending", pend, 0);
        rst_n = 1'b1;
        set_lvl(2, 3); set_lvl(1, 4); set_lvl(5, 4); set_lvl(6, 0);
        // Enable with level 3, request source 2 at level 3
        st_wr = 1'b1; st_wdata = 5'h0F; req_set = 8'h04; step();
        chk("R2 pending set", pend, 8'h04);
        step();
        chk("R3 equal level not taken", accept, 0);
        req_set = 8'h62; step();
        chk("R2 pending accumulate", pend, 8'h66);
        step();
        chk("R7 accept strobe", accept, 1);
        chk("R5 tie to lowest index", vector, 1);
        chk("R6 status after accept", status, 5'h10);
        chk("R6 saved status", saved, 5'h0F);
        chk("R7 winner bit cleared", pend, 8'h64);
        step();
        chk("R7 strobe one cycle", accept, 0);
        chk("R4 level 0 stays pending", pend[6], 1);
        nmi = 1'b1; step();
        step();
        chk("R8 nmi taken while disabled", acc_nmi, 1);
        chk("R8 nmi status", status, 5'h1C);
        st_wr = 1'b1; st_wdata = 5'h02; swi = 1'b1; swi_num = 6'd40; step();
        chk("R10 swi 40 keeps stack flag", status, 5'h02);
        swi = 1'b1; swi_num = 6'd31; step();
        chk("R10 swi 31 clears stack flag", status, 5'h00);
        st_wr = 1'b1; st_wdata = 5'h1F; step();
        chk("R9 status write", status, 5'h1F);
        step();
        chk("R3 level 7 blocks all", accept, 0);
        st_wr = 1'b1; st_wdata = 5'h03; step();
        st_wr = 1'b1; st_wdata = 5'h1F; step();
        chk("R9 accept wins over write", status, 5'h10);
        chk("R5 highest level wins", vector, 5);
        chk("R6 saved before accept", saved, 5'h03);
        // Random phase against the model
        for (int it = 0; it < 1500; it++) begin
            if (it % 60 == 0)
                for (int i = 0; i < N; i++) set_lvl(i, $urandom % 8);
            req_set = N'($urandom & $urandom & $urandom);
            nmi = ($urandom % 40) == 0;
            st_wr = ($urandom % 5) == 0;
            st_wdata = {3'($urandom % 8), 1'($urandom % 2), 1'(($urandom % 4) != 0)};
            swi = ($urandom % 12) == 0;
            swi_num = 6'($urandom % 64);
            step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule